// File: doc/BRIEF.md
# Receive Frame Alignment Padding Inserter

This block sits in an Ethernet receive path between frame reception and the receive data buffer. It carries a byte-wide frame stream and adds a programmable run of padding bytes at the head of every frame. Software picks the pad length so that a later header lands on a word boundary. For example, two pad bytes put the IP header of an untagged frame on a 32-bit boundary. The pad area can also carry a 64-bit timestamp that is captured when the frame starts.

The stream may begin with an offload control-block prefix of a fixed size. When the prefix is enabled, the padding goes after it. The padding always goes ahead of the first real frame byte. That byte is the preamble when the receive path keeps the preamble, and otherwise the first layer-2 header byte. While pad bytes go out, the input is held off through valid/ready backpressure, so no frame byte is lost or reordered.

Configuration can be written after reset, before the first frame. After that it is locked. It unlocks again only when a graceful receive stop has completed while no frame is in flight. Writes made while locked are dropped. The active settings, including the timer-enable input and the timestamp value, are captured when the start marker of a frame is first presented, and they stay fixed until that frame ends.

Top module: `rxpad_inserter`

## Requirements
- R1: With an effective pad length of zero, the output frame is byte-for-byte the input frame.
- R2: With the prefix disabled, a pad length N (1 to 31) puts exactly N pad bytes ahead of the first frame byte. The first frame byte is the preamble when the preamble is kept, and otherwise the first layer-2 header byte.
- R3: When timestamping is not active, every pad byte is 8'h00.
- R4: When timestamping is active and the programmed pad length is below 8, exactly 8 pad bytes are inserted. A programmed length of 8 or more is used as written.
- R5: When timestamping is active, the first 8 pad bytes carry the 64-bit timestamp, most-significant byte first (bits 63:56 first). Any further pad bytes are 8'h00.
- R6: With the timer-enable input low, timestamping is treated as off. Pad bytes are zero and no clamp to 8 applies.
- R7: With the prefix enabled, the first PFX_BYTES (default 8) input bytes pass through first, and the padding follows them. A frame that ends within its prefix gets no padding.
- R8: Configuration writes take effect only while unlocked. The block is unlocked from reset until the first frame start. It unlocks again when the receive-stop-done input is high while no frame is in progress. Writes made while locked are ignored.
- R9: Pad settings, the timer-enable input and the timestamp are sampled when a start marker is first presented while idle. Changes after that do not affect the frame.
- R10: While pad bytes are being emitted, in_ready is low. Frame bytes are never dropped or reordered. out_sop marks the first output byte of a frame and out_eop marks its last.
- R11: Input bytes that arrive while idle without a start marker are accepted and discarded, and they produce no output.
- R12: After reset, out_valid is low, all configuration fields are zero and the block is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_pad_len | input | 5 | Programmed pad length |
| cfg_stamp_en | input | 1 | Timestamp-in-pad enable |
| cfg_pfx_en | input | 1 | Control-block prefix present in stream |
| rx_stop_done | input | 1 | Graceful receive stop has completed |
| timer_en | input | 1 | Timer running; gates timestamping |
| ts_value | input | 64 | Current timestamp |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Input start of frame |
| in_eop | input | 1 | Input end of frame |
| in_ready | output | 1 | Input byte accepted |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | Output start of frame |
| out_eop | output | 1 | Output end of frame |
| out_ready | input | 1 | Downstream ready |

## Verification
A wrong pad counter or a wrong phase shows up at once in the output byte stream. A pad that is one byte short or long shifts every later byte of that frame, and the first shifted byte exposes it in the cycle it is transferred. Timestamp byte ordering and clamp errors show up in the pad bytes themselves, ahead of the frame data. A lock fault stays hidden until the next frame, which then comes out with the wrong pad layout. For that reason the bench follows every ignored write with a frame.

// File: rtl/rxpad_pkg.sv
package rxpad_pkg;

    localparam int PAD_W    = 5;
    localparam int TS_BYTES = 8;
    localparam int TS_W     = TS_BYTES * 8;
    localparam int TSI_W    = $clog2(TS_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PFX,
        ST_PAD,
        ST_BODY
    } phase_e;

    // Software-visible settings as held in the config register
    typedef struct packed {
        logic [PAD_W-1:0] pad_len;
        logic             stamp_en;
        logic             pfx_en;
    } rx_cfg_t;

    // Settings resolved for one frame
    typedef struct packed {
        logic [PAD_W-1:0] pad_eff;
        logic             stamp_on;
        logic             pfx_on;
    } frm_cfg_t;

    function automatic frm_cfg_t resolve_cfg(input rx_cfg_t c, input logic tmr_on);
        frm_cfg_t f;
        f.stamp_on = c.stamp_en & tmr_on;
        f.pfx_on   = c.pfx_en;
        f.pad_eff  = (f.stamp_on && (c.pad_len < PAD_W'(TS_BYTES))) ? PAD_W'(TS_BYTES)
                                                                     : c.pad_len;
        return f;
    endfunction

endpackage

// File: rtl/rxpad_cfg.sv
module rxpad_cfg
    import rxpad_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  rx_cfg_t wr_cfg,
    input  logic    stop_done,
    input  logic    frame_start,
    input  logic    idle,
    output rx_cfg_t cfg,
    output logic    locked
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            locked <= 1'b0;
        end else begin
            if (wr_en && !locked) begin
                cfg <= wr_cfg;
            end
            if (frame_start) begin
                locked <= 1'b1;
            end else if (stop_done && idle) begin
                locked <= 1'b0;
            end
        end
    end

    AST_CFG_FROZEN_WHILE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(cfg)); // R8

    AST_LOCK_AT_FRAME_START: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> locked); // R8

endmodule

// File: rtl/rxpad_ctrl.sv
module rxpad_ctrl
    import rxpad_pkg::*;
#(
    parameter int PFX_BYTES = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            in_sop,
    input  logic            in_eop,
    input  logic            in_fire,
    input  logic            out_fire,
    input  rx_cfg_t         cfg,
    input  logic            timer_en,
    input  logic [TS_W-1:0] ts_value,
    output phase_e          phase,
    output frm_cfg_t        frm,
    output logic [TS_W-1:0] ts_q,
    output logic [PAD_W-1:0] pad_idx,
    output logic            first_pend,
    output logic            frame_start
);

    localparam int PFX_CW = (PFX_BYTES > 1) ? $clog2(PFX_BYTES) : 1;
    localparam int CNT_W  = (PFX_CW > PAD_W) ? PFX_CW : PAD_W;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] pad_last;
    frm_cfg_t         nxt;

    assign nxt         = resolve_cfg(cfg, timer_en);
    assign frame_start = (phase == ST_IDLE) && in_valid && in_sop;
    assign pad_last    = CNT_W'(frm.pad_eff) - CNT_W'(1);
    assign pad_idx     = cnt[PAD_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= ST_IDLE;
            cnt        <= '0;
            frm        <= '0;
            ts_q       <= '0;
            first_pend <= 1'b0;
        end else begin
            if (out_fire) begin
                first_pend <= 1'b0;
            end
            case (phase)
                ST_IDLE: begin
                    if (frame_start) begin
                        frm        <= nxt;
                        ts_q       <= ts_value;
                        cnt        <= '0;
                        first_pend <= 1'b1;
                        if (nxt.pfx_on) begin
                            phase <= ST_PFX;
                        end else if (nxt.pad_eff != '0) begin
                            phase <= ST_PAD;
                        end else begin
                            phase <= ST_BODY;
                        end
                    end
                end
                ST_PFX: begin
                    if (in_fire) begin
                        if (in_eop) begin
                            phase <= ST_IDLE;
                        end else if (cnt == CNT_W'(PFX_BYTES - 1)) begin
                            cnt   <= '0;
                            phase <= (frm.pad_eff != '0) ? ST_PAD : ST_BODY;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                ST_PAD: begin
                    if (out_fire) begin
                        if (cnt == pad_last) begin
                            cnt   <= '0;
                            phase <= ST_BODY;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                default: begin
                    if (in_fire && in_eop) begin
                        phase <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    AST_STAMP_CLAMPS_TO_EIGHT: assert property (@(posedge clk) disable iff (rst)
        (phase != ST_IDLE && frm.stamp_on) |-> (frm.pad_eff >= PAD_W'(TS_BYTES))); // R4

    AST_PAD_INDEX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_PAD) |-> (CNT_W'(cnt) < CNT_W'(frm.pad_eff))); // R2

endmodule

// File: rtl/rxpad_mux.sv
module rxpad_mux
    import rxpad_pkg::*;
(
    input  phase_e           phase,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic             out_ready,
    input  logic             first_pend,
    input  logic             stamp_on,
    input  logic [PAD_W-1:0] pad_idx,
    input  logic [TS_W-1:0]  ts_q,
    output logic             in_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sop,
    output logic             out_eop
);

    logic [7:0] ts_bytes [TS_BYTES];
    logic [7:0] pad_data;

    // Byte b of the stamp, most significant first
    for (genvar b = 0; b < TS_BYTES; b++) begin : g_ts_slice
        assign ts_bytes[b] = ts_q[TS_W-1-8*b -: 8];
    end

    assign pad_data = (stamp_on && (pad_idx < PAD_W'(TS_BYTES))) ? ts_bytes[pad_idx[TSI_W-1:0]]
                                                                 : 8'h00;

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = in_data;
        out_sop   = 1'b0;
        out_eop   = 1'b0;
        case (phase)
            ST_IDLE: begin
                // stray bytes outside a frame are swallowed
                in_ready = in_valid & ~in_sop;
            end
            ST_PAD: begin
                out_valid = 1'b1;
                out_data  = pad_data;
                out_sop   = first_pend;
            end
            default: begin
                out_valid = in_valid;
                out_sop   = first_pend;
                out_eop   = in_eop;
                in_ready  = out_ready;
            end
        endcase
    end

endmodule

// File: rtl/rxpad_inserter.sv
module rxpad_inserter
    import rxpad_pkg::*;
#(
    parameter int PFX_BYTES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [4:0]  cfg_pad_len,
    input  logic        cfg_stamp_en,
    input  logic        cfg_pfx_en,
    input  logic        rx_stop_done,
    input  logic        timer_en,
    input  logic [63:0] ts_value,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_sop,
    input  logic        in_eop,
    output logic        in_ready,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_sop,
    output logic        out_eop,
    input  logic        out_ready
);

    rx_cfg_t          wr_cfg;
    rx_cfg_t          cur_cfg;
    logic             cfg_locked;
    phase_e           phase;
    frm_cfg_t         frm;
    logic [TS_W-1:0]  ts_q;
    logic [PAD_W-1:0] pad_idx;
    logic             first_pend;
    logic             frame_start;
    logic             in_fire;
    logic             out_fire;

    assign wr_cfg   = '{pad_len: cfg_pad_len, stamp_en: cfg_stamp_en, pfx_en: cfg_pfx_en};
    assign in_fire  = in_valid & in_ready;
    assign out_fire = out_valid & out_ready;

    rxpad_cfg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (cfg_wr),
        .wr_cfg      (wr_cfg),
        .stop_done   (rx_stop_done),
        .frame_start (frame_start),
        .idle        (phase == ST_IDLE),
        .cfg         (cur_cfg),
        .locked      (cfg_locked)
    );

    rxpad_ctrl #(.PFX_BYTES(PFX_BYTES)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_sop      (in_sop),
        .in_eop      (in_eop),
        .in_fire     (in_fire),
        .out_fire    (out_fire),
        .cfg         (cur_cfg),
        .timer_en    (timer_en),
        .ts_value    (ts_value),
        .phase       (phase),
        .frm         (frm),
        .ts_q        (ts_q),
        .pad_idx     (pad_idx),
        .first_pend  (first_pend),
        .frame_start (frame_start)
    );

    rxpad_mux u_mux (
        .phase      (phase),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_sop     (in_sop),
        .in_eop     (in_eop),
        .out_ready  (out_ready),
        .first_pend (first_pend),
        .stamp_on   (frm.stamp_on),
        .pad_idx    (pad_idx),
        .ts_q       (ts_q),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_sop    (out_sop),
        .out_eop    (out_eop)
    );

    AST_INPUT_HELD_DURING_PAD: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_PAD) |-> !in_ready); // R10

    AST_UNSTAMPED_PAD_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_PAD && !frm.stamp_on) |-> (out_data == 8'h00)); // R3

    AST_SOP_ONLY_ON_FIRST: assert property (@(posedge clk) disable iff (rst)
        (out_fire && !out_eop) |=> !out_sop); // R10

    AST_EOP_ENDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        (out_fire && out_eop) |=> (phase == ST_IDLE)); // R10

    AST_PAD_BYTE_HELD: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_PAD && !out_ready) |=> (out_valid && $stable(out_data))); // R10

    AST_CFG_LOCKED_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        (phase != ST_IDLE) |-> cfg_locked); // R8

endmodule

// File: tb/rxpad_inserter_tb.sv
module rxpad_inserter_tb;

    localparam int PFX_N = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [4:0]  cfg_pad_len;
    logic        cfg_stamp_en;
    logic        cfg_pfx_en;
    logic        rx_stop_done;
    logic        timer_en;
    logic [63:0] ts_value;
    logic        in_valid;
    logic [7:0]  in_data;
    logic        in_sop;
    logic        in_eop;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_sop;
    logic        out_eop;
    logic        out_ready;

    always #10 clk = ~clk;

    rxpad_inserter #(.PFX_BYTES(PFX_N)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .cfg_wr       (cfg_wr),
        .cfg_pad_len  (cfg_pad_len),
        .cfg_stamp_en (cfg_stamp_en),
        .cfg_pfx_en   (cfg_pfx_en),
        .rx_stop_done (rx_stop_done),
        .timer_en     (timer_en),
        .ts_value     (ts_value),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_sop       (in_sop),
        .in_eop       (in_eop),
        .in_ready     (in_ready),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_sop      (out_sop),
        .out_eop      (out_eop),
        .out_ready    (out_ready)
    );

    logic [9:0] exp_q [$];
    int         kind_q [$];
    int         n_chk = 0;
    int         n_bad = 0;
    int         cyc = 0;
    string      cur_req = "R12";
    logic [4:0] m_len = 5'd0;
    bit         m_stamp = 1'b0;
    bit         m_pfx = 1'b0;
    bit         m_locked = 1'b0;
    bit         bp_en = 1'b0;
    bit         gap_en = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        out_ready = bp_en ? ($urandom_range(0, 3) != 0) : 1'b1;
    end

    always @(negedge clk) begin : monitor
        logic [9:0] e;
        int         k;
        string      tag;
        #5;
        if (!rst && out_valid) begin
            if (exp_q.size() > 0 && kind_q[0] != 0)
                check(in_ready == 1'b0, "R10", "input stalled while padding", in_ready, 0);
            if (out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, cur_req, "unexpected output byte",
                          {out_sop, out_eop, out_data}, 0);
                end else begin
                    e   = exp_q.pop_front();
                    k   = kind_q.pop_front();
                    tag = (k == 2) ? "R5" : ((k == 1) ? "R3" : "R10");
                    check({out_sop, out_eop, out_data} == e, {cur_req, "/", tag},
                          "output beat {sop,eop,data}", {out_sop, out_eop, out_data}, e);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL R10 watchdog: actual %0d cycles expected completion", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Starts and returns just after a falling edge
    task automatic push_byte(input logic [7:0] d, input bit s, input bit e);
        if (gap_en) repeat ($urandom_range(0, 2)) @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_sop   = s;
        in_eop   = e;
        #5;
        while (!in_ready) begin
            @(negedge clk);
            #5;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
    endtask

    task automatic send_frame(input int len, input bit flip);
        logic [7:0] body [$];
        logic [7:0] od [$];
        int         ok [$];
        bit         st;
        int         eff;
        int         pos;
        bit         do_pad;
        for (int i = 0; i < len; i++) body.push_back(8'($urandom));
        st     = m_stamp && timer_en;
        eff    = (st && m_len < 5'd8) ? 8 : int'(m_len);
        do_pad = !m_pfx || (len > PFX_N);
        pos    = m_pfx ? PFX_N : 0;
        for (int i = 0; i < len; i++) begin
            if (do_pad && i == pos) begin
                for (int j = 0; j < eff; j++) begin
                    if (st && j < 8) begin
                        od.push_back(ts_value[63-8*j -: 8]);
                        ok.push_back(2);
                    end else begin
                        od.push_back(8'h00);
                        ok.push_back(1);
                    end
                end
            end
            od.push_back(body[i]);
            ok.push_back(0);
        end
        for (int i = 0; i < od.size(); i++) begin
            exp_q.push_back({(i == 0), (i == od.size() - 1), od[i]});
            kind_q.push_back(ok[i]);
        end
        m_locked = 1'b1;
        for (int i = 0; i < len; i++) begin
            push_byte(body[i], (i == 0), (i == len - 1));
            if (flip && i == 0) begin
                timer_en = ~timer_en;
                ts_value = {$urandom, $urandom};
            end
        end
    endtask

    task automatic cfg_write(input logic [4:0] l, input bit s, input bit p);
        cfg_wr       = 1'b1;
        cfg_pad_len  = l;
        cfg_stamp_en = s;
        cfg_pfx_en   = p;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (!m_locked) begin
            m_len   = l;
            m_stamp = s;
            m_pfx   = p;
        end
    endtask

    task automatic stop_rx();
        rx_stop_done = 1'b1;
        @(negedge clk);
        rx_stop_done = 1'b0;
        m_locked = 1'b0;
    endtask

    task automatic reconfig(input logic [4:0] l, input bit s, input bit p);
        stop_rx();
        cfg_write(l, s, p);
    endtask

    task automatic drain();
        int t = 0;
        while (exp_q.size() != 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, cur_req, "frame fully delivered", exp_q.size(), 0);
    endtask

    initial begin
        void'($urandom(32'd20240613));
        rst = 1'b1;
        cfg_wr = 1'b0; cfg_pad_len = '0; cfg_stamp_en = 1'b0; cfg_pfx_en = 1'b0;
        rx_stop_done = 1'b0; timer_en = 1'b1; ts_value = 64'h0123_4567_89AB_CDEF;
        in_valid = 1'b0; in_data = '0; in_sop = 1'b0; in_eop = 1'b0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #5;
        // R12: idle outputs after reset
        check(out_valid == 1'b0, "R12", "out_valid after reset", out_valid, 0);
        check(in_ready == 1'b0, "R12", "in_ready idle after reset", in_ready, 0);
        @(negedge clk);

        // R12 / R1: zero config after reset, frame passes unchanged
        cur_req = "R1"; send_frame(20, 1'b0); drain();

        // R8: write while locked is ignored
        cur_req = "R8"; cfg_write(5'd5, 1'b1, 1'b0); send_frame(16, 1'b0); drain();

        // R2 / R3: two zero pad bytes ahead of the frame
        cur_req = "R2"; reconfig(5'd2, 1'b0, 1'b0); send_frame(30, 1'b0); drain();
        cur_req = "R2"; reconfig(5'd31, 1'b0, 1'b0); send_frame(5, 1'b0); drain();
        cur_req = "R2"; reconfig(5'd1, 1'b0, 1'b0); send_frame(1, 1'b0); drain();

        // R4 / R5: clamp to 8 and stamp bytes MSB first
        cur_req = "R4"; ts_value = 64'hA1B2_C3D4_E5F6_0718;
        reconfig(5'd3, 1'b1, 1'b0); send_frame(10, 1'b0); drain();
        cur_req = "R5"; ts_value = 64'hFEDC_BA98_7654_3210;
        reconfig(5'd12, 1'b1, 1'b0); send_frame(10, 1'b0); drain();

        // R9: timer enable and stamp changed after start marker
        cur_req = "R9"; timer_en = 1'b1; ts_value = 64'h1122_3344_5566_7788;
        reconfig(5'd3, 1'b1, 1'b0); send_frame(12, 1'b1); drain();

        // R6: timer off disables stamping and the clamp
        cur_req = "R6"; timer_en = 1'b0; send_frame(9, 1'b0); drain();
        timer_en = 1'b1;

        // R7: pad after prefix; frame ending inside prefix gets no pad
        cur_req = "R7"; reconfig(5'd4, 1'b1, 1'b1); send_frame(20, 1'b0); drain();
        cur_req = "R7"; send_frame(PFX_N, 1'b0); drain();
        cur_req = "R7"; send_frame(3, 1'b0); drain();
        cur_req = "R7"; reconfig(5'd0, 1'b0, 1'b1); send_frame(12, 1'b0); drain();

        // R11: stray bytes while idle are dropped
        cur_req = "R11"; push_byte(8'h5A, 1'b0, 1'b0); push_byte(8'hC3, 1'b0, 1'b1);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R11", "stray bytes produce nothing", exp_q.size(), 0);
        send_frame(9, 1'b0); drain();

        // Random mix: R10 ordering under backpressure and gaps
        cur_req = "R10";
        for (int f = 0; f < 150; f++) begin
            bp_en    = ($urandom_range(0, 1) == 1);
            gap_en   = ($urandom_range(0, 1) == 1);
            timer_en = ($urandom_range(0, 3) != 0);
            ts_value = {$urandom, $urandom};
            if ($urandom_range(0, 2) != 0)
                reconfig(5'($urandom), 1'($urandom), 1'($urandom));
            else
                cfg_write(5'($urandom), 1'($urandom), 1'($urandom));
            send_frame($urandom_range(1, 40), 1'($urandom_range(0, 1)));
            drain();
        end
        bp_en = 1'b0;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule